// File: doc/BRIEF.md
# CSI-2 Capture Context Filter

This block sits downstream of a CSI-2 packet decoder and picks out the packets that belong to one capture context. The decoder presents each packet as a one-cycle header beat carrying the virtual channel and data type. A long packet is then followed by its payload bytes, each marked valid, with a last flag on the final byte. The filter forwards the payload of matching long packets as a byte stream. Each byte carries a programmable port tag, and the last byte of each accepted packet is marked as a line end. Frame-start and frame-end short packets on the context's channel produce one-cycle marker pulses.

Software programs the context through a single write strobe. The strobe carries an enable, a virtual channel, a data type, a per-frame line limit and a port tag. A written value is staged and only becomes active at the next frame start on the staged channel. The single exception is a write of all zeros, which stops the context at once. Once a frame has delivered its programmed number of lines, further long packets are dropped until the next frame start. A data-type setting of 0x01 matches every long-packet type. Typical long types are 0x1E (YUV422), 0x24 (RGB888), 0x2A (RAW8) and 0x2B (RAW10).

Top module: `csi_ctx_filter`

## Requirements
- R1: A long packet (header data type 0x10 or above) whose virtual channel and data type equal the active settings has every payload byte forwarded unchanged and in order on `out_data` with `out_valid`, one cycle after the byte is presented.
- R2: A long packet whose virtual channel or data type differs from the active settings produces no `out_valid`.
- R3: With an active data-type setting of 0x01, long packets of any data type on the active virtual channel are forwarded.
- R4: Every forwarded byte carries on `out_port` the port tag that was made active by the latest frame start.
- R5: `out_eol` is high together with `out_valid` on the last payload byte of each accepted packet, and low on all other bytes.
- R6: A frame-start short packet (data type 0x00) on the staged virtual channel, while the staged enable is set, pulses `out_fs` for one cycle on the next cycle. It also copies the staged settings to the active ones and restarts the line count.
- R7: A frame-end short packet (data type 0x01) on the active virtual channel of an enabled context pulses `out_fe` for one cycle on the next cycle.
- R8: After the number of long packets accepted since the last frame start reaches the active line limit, later long packets are dropped until the next frame start.
- R9: A configuration write with every field zero disables the context from the following cycle. After such a write, no payload, frame-start or frame-end output appears.
- R10: A configuration write other than all zeros leaves filtering, port tag and line limit unchanged until the next frame start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_en | input | 1 | Context enable to stage |
| cfg_vc | input | VC_W | Virtual channel to stage |
| cfg_dt | input | DT_W | Data type to stage (0x01 = any) |
| cfg_lines | input | LINE_W | Lines per frame to stage |
| cfg_port | input | PORT_W | Output port tag to stage |
| hdr_valid | input | 1 | Packet header beat |
| hdr_vc | input | VC_W | Header virtual channel |
| hdr_dt | input | DT_W | Header data type |
| pay_valid | input | 1 | Payload byte valid |
| pay_data | input | 8 | Payload byte |
| pay_last | input | 1 | Last payload byte of the packet |
| out_valid | output | 1 | Forwarded byte valid |
| out_data | output | 8 | Forwarded byte |
| out_port | output | PORT_W | Port tag of the forwarded byte |
| out_eol | output | 1 | Line end, last byte of a packet |
| out_fs | output | 1 | Frame-start marker pulse |
| out_fe | output | 1 | Frame-end marker pulse |

## Verification
The assertions assume a well-formed decoder stream. A header beat never coincides with a payload byte, payload bytes appear only after a long header, and each long packet ends with a byte marked last. Under those assumptions, accepted packets never overlap and the port tag cannot change between two back-to-back forwarded bytes. The bench drives packets only through tasks that emit a header and then an uninterrupted run of payload bytes. It keeps idle cycles between packets and never writes the configuration while a packet is in flight.

// File: rtl/csi_ctx_filter.sv
module csi_ctx_filter #(
  parameter int VC_W   = 2,
  parameter int DT_W   = 6,
  parameter int LINE_W = 12,
  parameter int PORT_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic              cfg_en,
  input  logic [VC_W-1:0]   cfg_vc,
  input  logic [DT_W-1:0]   cfg_dt,
  input  logic [LINE_W-1:0] cfg_lines,
  input  logic [PORT_W-1:0] cfg_port,
  input  logic              hdr_valid,
  input  logic [VC_W-1:0]   hdr_vc,
  input  logic [DT_W-1:0]   hdr_dt,
  input  logic              pay_valid,
  input  logic [7:0]        pay_data,
  input  logic              pay_last,
  output logic              out_valid,
  output logic [7:0]        out_data,
  output logic [PORT_W-1:0] out_port,
  output logic              out_eol,
  output logic              out_fs,
  output logic              out_fe
);
  localparam logic [DT_W-1:0] DT_FS   = DT_W'(0);
  localparam logic [DT_W-1:0] DT_FE   = DT_W'(1);
  localparam logic [DT_W-1:0] DT_ANY  = DT_W'(1);
  localparam logic [DT_W-1:0] DT_LONG = DT_W'(16);

  logic              stg_en, act_en, pkt_pass;
  logic [VC_W-1:0]   stg_vc, act_vc;
  logic [DT_W-1:0]   stg_dt, act_dt;
  logic [LINE_W-1:0] stg_lines, act_lines, line_cnt;
  logic [PORT_W-1:0] stg_port, act_port;

  wire zero_wr = cfg_we && !cfg_en && cfg_vc == '0 && cfg_dt == '0 &&
                 cfg_lines == '0 && cfg_port == '0;
  wire is_long = hdr_dt >= DT_LONG;
  wire fs_hit  = hdr_dt == DT_FS && stg_en && hdr_vc == stg_vc;
  wire fe_hit  = hdr_dt == DT_FE && act_en && hdr_vc == act_vc;
  wire lp_hit  = is_long && act_en && hdr_vc == act_vc &&
                 (act_dt == DT_ANY || hdr_dt == act_dt) && line_cnt < act_lines;

  assign out_port = act_port;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      {stg_en, stg_vc, stg_dt, stg_lines, stg_port} <= '0;
      {act_en, act_vc, act_dt, act_lines, act_port} <= '0;
      line_cnt  <= '0;
      pkt_pass  <= 1'b0;
      out_valid <= 1'b0;
      out_data  <= '0;
      out_eol   <= 1'b0;
      out_fs    <= 1'b0;
      out_fe    <= 1'b0;
    end else begin
      out_valid <= 1'b0;
      out_eol   <= 1'b0;
      out_fs    <= 1'b0;
      out_fe    <= 1'b0;
      if (cfg_we) {stg_en, stg_vc, stg_dt, stg_lines, stg_port} <=
                  {cfg_en, cfg_vc, cfg_dt, cfg_lines, cfg_port};
      if (zero_wr) begin
        act_en   <= 1'b0;
        pkt_pass <= 1'b0;
      end else if (hdr_valid) begin
        if (fs_hit) begin
          {act_en, act_vc, act_dt, act_lines, act_port} <=
            {stg_en, stg_vc, stg_dt, stg_lines, stg_port};
          line_cnt <= '0;
          pkt_pass <= 1'b0;
          out_fs   <= 1'b1;
        end else if (fe_hit) begin
          out_fe   <= 1'b1;
          pkt_pass <= 1'b0;
        end else begin
          pkt_pass <= lp_hit;
          if (lp_hit) line_cnt <= line_cnt + 1'b1;
        end
      end else if (pay_valid) begin
        if (pkt_pass) begin
          out_valid <= 1'b1;
          out_data  <= pay_data;
          out_eol   <= pay_last;
        end
        if (pay_last) pkt_pass <= 1'b0;
      end
    end
  end
endmodule

module csi_ctx_filter_chk #(
  parameter int VC_W   = 2,
  parameter int DT_W   = 6,
  parameter int LINE_W = 12,
  parameter int PORT_W = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_we,
  input logic              cfg_en,
  input logic [VC_W-1:0]   cfg_vc,
  input logic [DT_W-1:0]   cfg_dt,
  input logic [LINE_W-1:0] cfg_lines,
  input logic [PORT_W-1:0] cfg_port,
  input logic              out_valid,
  input logic              out_eol,
  input logic              out_fs,
  input logic              out_fe,
  input logic [PORT_W-1:0] out_port,
  input logic              act_en,
  input logic [LINE_W-1:0] line_cnt,
  input logic [LINE_W-1:0] act_lines
);
  assert_eol_with_data_R5: assert property (@(posedge clk) disable iff (!rst_n)
    out_eol |-> out_valid);
  assert_fs_alone_R6: assert property (@(posedge clk) disable iff (!rst_n)
    out_fs |-> !out_valid && !out_fe);
  assert_zero_write_stops_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && !cfg_en && cfg_vc == '0 && cfg_dt == '0 && cfg_lines == '0 && cfg_port == '0)
    |=> !out_valid && !out_fs && !act_en);
  assert_disabled_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !act_en |=> !out_valid);
  assert_line_cap_R8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> line_cnt <= act_lines);
  assert_port_steady_R4: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && $past(out_valid) |-> $stable(out_port));
endmodule

bind csi_ctx_filter csi_ctx_filter_chk #(
  .VC_W(VC_W), .DT_W(DT_W), .LINE_W(LINE_W), .PORT_W(PORT_W)
) chk_i (.*);

// File: tb/csi_ctx_filter_tb_top.sv
module csi_ctx_filter_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 1'b0, cfg_en = 1'b0;
  logic [1:0] cfg_vc = '0;
  logic [5:0] cfg_dt = '0;
  logic [11:0] cfg_lines = '0;
  logic [2:0] cfg_port = '0;
  logic hdr_valid = 1'b0;
  logic [1:0] hdr_vc = '0;
  logic [5:0] hdr_dt = '0;
  logic pay_valid = 1'b0, pay_last = 1'b0;
  logic [7:0] pay_data = '0;
  logic out_valid, out_eol, out_fs, out_fe;
  logic [7:0] out_data;
  logic [2:0] out_port;

  int n_tests = 0, n_fail = 0;
  int got_n = 0, fs_n = 0, fe_n = 0, eol_n = 0, eol_bad = 0;
  logic [7:0] got_d [64];
  logic [2:0] got_p [64];

  always #10 clk = ~clk;

  csi_ctx_filter dut_i (.*);

  always @(posedge clk) begin
    #5;
    if (out_valid && got_n < 64) begin
      got_d[got_n] = out_data;
      got_p[got_n] = out_port;
      got_n++;
    end
    if (out_fs) fs_n++;
    if (out_fe) fe_n++;
    if (out_eol) eol_n++;
    if (out_eol && !out_valid) eol_bad++;
  end

  task automatic check(input string tag, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic clear_mon();
    @(negedge clk);
    got_n = 0; fs_n = 0; fe_n = 0; eol_n = 0; eol_bad = 0;
  endtask

  task automatic write_cfg(input logic en, input logic [1:0] vc, input logic [5:0] dt,
                           input logic [11:0] lines, input logic [2:0] port);
    @(negedge clk);
    cfg_we = 1'b1; cfg_en = en; cfg_vc = vc; cfg_dt = dt; cfg_lines = lines; cfg_port = port;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic send_short(input logic [1:0] vc, input logic [5:0] dt);
    @(negedge clk);
    hdr_valid = 1'b1; hdr_vc = vc; hdr_dt = dt;
    @(negedge clk);
    hdr_valid = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic send_long(input logic [1:0] vc, input logic [5:0] dt,
                           input int len, input logic [7:0] seed);
    @(negedge clk);
    hdr_valid = 1'b1; hdr_vc = vc; hdr_dt = dt;
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      hdr_valid = 1'b0;
      pay_valid = 1'b1; pay_data = seed + 8'(i); pay_last = (i == len - 1);
    end
    @(negedge clk);
    pay_valid = 1'b0; pay_last = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic t_reset();
    check("reset out_valid", int'(out_valid), 0);
    check("reset out_fs/out_fe", int'(out_fs | out_fe), 0);
  endtask

  task automatic t_start_and_forward();
    int ok = 1;
    write_cfg(1'b1, 2'd1, 6'h2A, 12'd3, 3'd5);
    clear_mon();
    send_long(2'd1, 6'h2A, 4, 8'h10);
    check("R10 staged config inactive before frame start", got_n, 0);
    clear_mon();
    send_short(2'd1, 6'h00);
    check("R6 frame start marker", fs_n, 1);
    clear_mon();
    send_long(2'd1, 6'h2A, 4, 8'h10);
    check("R1 byte count", got_n, 4);
    for (int i = 0; i < 4; i++) if (got_d[i] != 8'h10 + 8'(i)) ok = 0;
    check("R1 byte values", ok, 1);
    check("R4 port tag", int'(got_p[0]), 5);
    check("R5 one line end", eol_n, 1);
    check("R5 line end only with data", eol_bad, 0);
  endtask

  task automatic t_mismatch();
    clear_mon();
    send_long(2'd2, 6'h2A, 3, 8'h40);
    check("R2 wrong vc dropped", got_n, 0);
    send_long(2'd1, 6'h24, 3, 8'h40);
    check("R2 wrong dt dropped", got_n, 0);
  endtask

  task automatic t_line_cap();
    clear_mon();
    send_long(2'd1, 6'h2A, 2, 8'h50);
    send_long(2'd1, 6'h2A, 2, 8'h60);
    check("R8 lines within cap", got_n, 4);
    clear_mon();
    send_long(2'd1, 6'h2A, 2, 8'h70);
    check("R8 line beyond cap dropped", got_n, 0);
    send_short(2'd1, 6'h01);
    check("R7 frame end marker", fe_n, 1);
    send_short(2'd1, 6'h00);
    send_long(2'd1, 6'h2A, 2, 8'h80);
    check("R8 count restarts at frame start", got_n, 2);
  endtask

  task automatic t_wildcard();
    write_cfg(1'b1, 2'd1, 6'h01, 12'd8, 3'd2);
    clear_mon();
    send_long(2'd1, 6'h2A, 2, 8'h90);
    check("R10 old dt still active", got_n, 2);
    check("R10 old port still active", int'(got_p[0]), 5);
    clear_mon();
    send_long(2'd1, 6'h24, 2, 8'h90);
    check("R10 wildcard not active before frame start", got_n, 0);
    send_short(2'd1, 6'h00);
    clear_mon();
    send_long(2'd1, 6'h24, 3, 8'hA0);
    send_long(2'd1, 6'h1E, 4, 8'hB0);
    check("R3 wildcard passes two types", got_n, 7);
    check("R3 wildcard data", int'(got_d[3]), 8'hB0);
    check("R4 new port after frame start", int'(got_p[6]), 2);
  endtask

  task automatic t_zero_write();
    write_cfg(1'b0, 2'd0, 6'h00, 12'd0, 3'd0);
    clear_mon();
    send_long(2'd1, 6'h24, 3, 8'hC0);
    check("R9 payload stopped", got_n, 0);
    send_short(2'd1, 6'h01);
    send_short(2'd1, 6'h00);
    send_short(2'd0, 6'h00);
    check("R9 no markers", fs_n + fe_n, 0);
    send_long(2'd0, 6'h24, 3, 8'hC0);
    check("R9 nothing after frame start attempts", got_n, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_start_and_forward();
    t_mismatch();
    t_line_cap();
    t_wildcard();
    t_zero_write();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #2000000;
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule